// File: doc/BRIEF.md
# Channel Charge Sum and Peak Finder

This block takes one set of digitized photodetector charges per clock cycle and reduces it to a small set of trigger figures. In its normal mode it reports the total charge over all channels, the largest single charge, the channel that holds that charge, and a flag saying whether any channel sat at full scale. In patch mode the channels are split into equal groups. The block then reports the charge sum of each group, plus the lowest-numbered group whose sum is above a programmable minimum.

All results for one sample set are packed into one 48-bit word for a board-to-board link. A new sample set may be offered on every cycle. The mode select and the threshold are sampled together with the data, so each set carries its own settings through the pipeline. A valid flag travels alongside the data. The link word holds its last value in cycles that carry no result.

Default configuration: 16 channels of 10 bits each, in four patches of four channels.

Top module: `chsum_maxfind_top`

## Requirements
- R1: In normal mode (bit 47 = 0), bits [13:0] of the link word hold the exact sum of all 16 channel charges (at most 16368, so it never overflows), and bits [31:14] are zero.
- R2: In normal mode, bits [41:32] hold the largest channel charge and bits [45:42] hold that channel's number. On a tie the lowest channel number is reported. With all inputs zero the number is 0.
- R3: In normal mode, bit 46 is 1 exactly when at least one channel equals full scale (1023).
- R4: Bit 47 of the link word equals the mode bit sampled with the data: 0 for normal, 1 for patch.
- R5: In patch mode, patch p covers channels 4p to 4p+3. Its 12-bit sum, shifted right by one, occupies bits [11p+10:11p] for p = 0..3.
- R6: In patch mode, bit 46 is 1 exactly when some patch sum is strictly greater than the threshold sampled with the data. Bits [45:44] then hold the lowest such patch number; otherwise both bits are 0.
- R7: A sample set presented with in_valid high before clock edge k shows its result, with out_valid high, after edge k+2 (three register stages). Back-to-back sets are accepted on every cycle, and out_valid is the in_valid stream delayed by three cycles.
- R8: After reset out_valid is 0 and link_word is 0. In a cycle where out_valid is 0, link_word keeps its previous value.
- R9: The mode and the threshold are sampled per sample set. Consecutive sets with different modes or thresholds each get their own encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample set present this cycle |
| in_charges | input | 160 | Channel c charge at bits [10c+9:10c] |
| patch_mode | input | 1 | 1 selects patch encoding for this set |
| patch_thr | input | 12 | Minimum patch charge for this set (strict compare) |
| out_valid | output | 1 | link_word carries a new result |
| link_word | output | 48 | Packed result word |

## Verification
The bench goes after ties for the maximum, where a design comparing with >= instead of > would report the higher channel. It applies all-full-scale inputs: a sum narrower than 14 bits would wrap there, and a missing saturation flag shows at once. Patch thresholds are placed exactly equal to a patch sum and one below it, which exposes a >= versus > slip in the hit test. The bench also sends back-to-back sets that flip the mode and threshold every cycle with gaps in valid, so that settings not carried through the pipeline, or a word that changes while invalid, show up as wrong fields.

// File: rtl/chsum_pkg.sv
package chsum_pkg;
  localparam int LINK_W = 48;
  typedef enum logic {LINK_FULL = 1'b0, LINK_PATCH = 1'b1} link_mode_e;
endpackage

// File: rtl/chsum_patch_reduce.sv
module chsum_patch_reduce #(
  parameter int CH_W     = 10,
  parameter int PATCH_SZ = 4,
  localparam int LIDX_W  = (PATCH_SZ > 1) ? $clog2(PATCH_SZ) : 1,
  localparam int PS_W    = CH_W + LIDX_W
) (
  input  logic [PATCH_SZ*CH_W-1:0] ch,
  output logic [PS_W-1:0]          psum,
  output logic [CH_W-1:0]          lmax,
  output logic [LIDX_W-1:0]        lidx,
  output logic                     lsat
);
  localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

  function automatic logic [PS_W-1:0] add_group(input logic [PATCH_SZ*CH_W-1:0] v);
    logic [PS_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PATCH_SZ; i++) acc = acc + PS_W'(v[i*CH_W +: CH_W]);
    return acc;
  endfunction

  // strict compare keeps the lowest index on ties
  function automatic logic [CH_W+LIDX_W-1:0] peak_of(input logic [PATCH_SZ*CH_W-1:0] v);
    logic [CH_W-1:0]   best;
    logic [LIDX_W-1:0] bi;
    best = v[CH_W-1:0];
    bi   = '0;
    for (int i = 1; i < PATCH_SZ; i++) begin
      if (v[i*CH_W +: CH_W] > best) begin
        best = v[i*CH_W +: CH_W];
        bi   = LIDX_W'(i);
      end
    end
    return {best, bi};
  endfunction

  function automatic logic any_full(input logic [PATCH_SZ*CH_W-1:0] v);
    logic f;
    f = 1'b0;
    for (int i = 0; i < PATCH_SZ; i++) f = f | (v[i*CH_W +: CH_W] == FULL);
    return f;
  endfunction

  always_comb begin
    psum         = add_group(ch);
    {lmax, lidx} = peak_of(ch);
    lsat         = any_full(ch);
  end
endmodule

// File: rtl/chsum_merge.sv
module chsum_merge #(
  parameter int N_PATCH = 4,
  parameter int CH_W    = 10,
  parameter int LIDX_W  = 2,
  parameter int PS_W    = 12,
  localparam int PIDX_W = (N_PATCH > 1) ? $clog2(N_PATCH) : 1,
  localparam int IDX_W  = PIDX_W + LIDX_W,
  localparam int SUM_W  = PS_W + PIDX_W
) (
  input  logic [N_PATCH*PS_W-1:0]   psum_f,
  input  logic [N_PATCH*CH_W-1:0]   lmax_f,
  input  logic [N_PATCH*LIDX_W-1:0] lidx_f,
  input  logic [N_PATCH-1:0]        lsat,
  input  logic [PS_W-1:0]           thr,
  output logic [SUM_W-1:0]          total,
  output logic [CH_W-1:0]           gmax,
  output logic [IDX_W-1:0]          gidx,
  output logic                      any_sat,
  output logic                      hit,
  output logic [PIDX_W-1:0]         hit_idx
);
  function automatic logic [SUM_W-1:0] add_patches(input logic [N_PATCH*PS_W-1:0] v);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < N_PATCH; p++) acc = acc + SUM_W'(v[p*PS_W +: PS_W]);
    return acc;
  endfunction

  function automatic logic [CH_W+IDX_W-1:0] pick_peak(input logic [N_PATCH*CH_W-1:0] m,
                                                      input logic [N_PATCH*LIDX_W-1:0] li);
    logic [CH_W-1:0]  best;
    logic [IDX_W-1:0] bi;
    best = m[CH_W-1:0];
    bi   = {PIDX_W'(0), li[LIDX_W-1:0]};
    for (int p = 1; p < N_PATCH; p++) begin
      if (m[p*CH_W +: CH_W] > best) begin
        best = m[p*CH_W +: CH_W];
        bi   = {PIDX_W'(p), li[p*LIDX_W +: LIDX_W]};
      end
    end
    return {best, bi};
  endfunction

  // scan downwards so the lowest qualifying patch is left last
  function automatic logic [PIDX_W:0] first_over(input logic [N_PATCH*PS_W-1:0] v,
                                                 input logic [PS_W-1:0] t);
    logic             f;
    logic [PIDX_W-1:0] idx;
    f   = 1'b0;
    idx = '0;
    for (int p = N_PATCH - 1; p >= 0; p--) begin
      if (v[p*PS_W +: PS_W] > t) begin
        f   = 1'b1;
        idx = PIDX_W'(p);
      end
    end
    return {f, idx};
  endfunction

  always_comb begin
    total          = add_patches(psum_f);
    {gmax, gidx}   = pick_peak(lmax_f, lidx_f);
    any_sat        = |lsat;
    {hit, hit_idx} = first_over(psum_f, thr);
  end
endmodule

// File: rtl/chsum_pack.sv
module chsum_pack
  import chsum_pkg::*;
#(
  parameter int N_PATCH = 4,
  parameter int CH_W    = 10,
  parameter int PS_W    = 12,
  parameter int IDX_W   = 4,
  parameter int PIDX_W  = 2,
  parameter int SUM_W   = 14
) (
  input  link_mode_e              mode,
  input  logic [SUM_W-1:0]        total,
  input  logic [CH_W-1:0]         gmax,
  input  logic [IDX_W-1:0]        gidx,
  input  logic                    any_sat,
  input  logic [N_PATCH*PS_W-1:0] psum_f,
  input  logic                    hit,
  input  logic [PIDX_W-1:0]       hit_idx,
  output logic [LINK_W-1:0]       word
);
  localparam int FLAG_BIT = LINK_W - 2;
  localparam int IDX_LSB  = FLAG_BIT - IDX_W;
  localparam int MAX_LSB  = IDX_LSB - CH_W;
  localparam int PF_W     = (LINK_W - 4) / N_PATCH;
  localparam int PS_SHIFT = PS_W - PF_W;

  function automatic logic [LINK_W-1:0] pack_full(input logic [SUM_W-1:0] s,
                                                  input logic [CH_W-1:0] m,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic f);
    logic [LINK_W-1:0] w;
    w = '0;
    w[SUM_W-1:0]             = s;
    w[MAX_LSB +: CH_W]       = m;
    w[IDX_LSB +: IDX_W]      = i;
    w[FLAG_BIT]              = f;
    w[LINK_W-1]              = LINK_FULL;
    return w;
  endfunction

  function automatic logic [LINK_W-1:0] pack_patch(input logic [N_PATCH*PS_W-1:0] v,
                                                   input logic h,
                                                   input logic [PIDX_W-1:0] hi);
    logic [LINK_W-1:0] w;
    logic [PS_W-1:0]   shifted;
    w = '0;
    for (int p = 0; p < N_PATCH; p++) begin
      shifted         = v[p*PS_W +: PS_W] >> PS_SHIFT;
      w[p*PF_W +: PF_W] = shifted[PF_W-1:0];
    end
    w[FLAG_BIT-1 -: PIDX_W] = hi;
    w[FLAG_BIT]             = h;
    w[LINK_W-1]             = LINK_PATCH;
    return w;
  endfunction

  always_comb begin
    if (mode == LINK_PATCH) word = pack_patch(psum_f, hit, hit_idx);
    else                    word = pack_full(total, gmax, gidx, any_sat);
  end
endmodule

// File: rtl/chsum_maxfind_top.sv
module chsum_maxfind_top
  import chsum_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int CH_W     = 10,
  parameter int PATCH_SZ = 4,
  localparam int N_PATCH = N_CH / PATCH_SZ,
  localparam int LIDX_W  = (PATCH_SZ > 1) ? $clog2(PATCH_SZ) : 1,
  localparam int PIDX_W  = (N_PATCH > 1) ? $clog2(N_PATCH) : 1,
  localparam int IDX_W   = PIDX_W + LIDX_W,
  localparam int PS_W    = CH_W + LIDX_W,
  localparam int SUM_W   = PS_W + PIDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [N_CH*CH_W-1:0]   in_charges,
  input  logic                   patch_mode,
  input  logic [PS_W-1:0]        patch_thr,
  output logic                   out_valid,
  output logic [LINK_W-1:0]      link_word
);
  // stage A: per-patch reduction
  logic [N_PATCH*PS_W-1:0]   r_psum,  a_psum;
  logic [N_PATCH*CH_W-1:0]   r_lmax,  a_lmax;
  logic [N_PATCH*LIDX_W-1:0] r_lidx,  a_lidx;
  logic [N_PATCH-1:0]        r_lsat,  a_lsat;
  logic                      a_valid;
  link_mode_e                a_mode;
  logic [PS_W-1:0]           a_thr;

  for (genvar p = 0; p < N_PATCH; p++) begin : g_patch
    chsum_patch_reduce #(.CH_W(CH_W), .PATCH_SZ(PATCH_SZ)) u_red (
      .ch   (in_charges[p*PATCH_SZ*CH_W +: PATCH_SZ*CH_W]),
      .psum (r_psum[p*PS_W +: PS_W]),
      .lmax (r_lmax[p*CH_W +: CH_W]),
      .lidx (r_lidx[p*LIDX_W +: LIDX_W]),
      .lsat (r_lsat[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_mode  <= LINK_FULL;
      a_thr   <= '0;
      a_psum  <= '0;
      a_lmax  <= '0;
      a_lidx  <= '0;
      a_lsat  <= '0;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_mode <= link_mode_e'(patch_mode);
        a_thr  <= patch_thr;
        a_psum <= r_psum;
        a_lmax <= r_lmax;
        a_lidx <= r_lidx;
        a_lsat <= r_lsat;
      end
    end
  end

  // stage B: merge across patches
  logic [SUM_W-1:0]        m_total, b_total;
  logic [CH_W-1:0]         m_gmax,  b_gmax;
  logic [IDX_W-1:0]        m_gidx,  b_gidx;
  logic                    m_sat,   b_sat;
  logic                    m_hit,   b_hit;
  logic [PIDX_W-1:0]       m_hidx,  b_hidx;
  logic [N_PATCH*PS_W-1:0] b_psum;
  logic                    b_valid;
  link_mode_e              b_mode;

  chsum_merge #(.N_PATCH(N_PATCH), .CH_W(CH_W), .LIDX_W(LIDX_W), .PS_W(PS_W)) u_merge (
    .psum_f (a_psum), .lmax_f (a_lmax), .lidx_f (a_lidx), .lsat (a_lsat),
    .thr    (a_thr),
    .total  (m_total), .gmax (m_gmax), .gidx (m_gidx), .any_sat (m_sat),
    .hit    (m_hit),   .hit_idx (m_hidx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_mode  <= LINK_FULL;
      b_total <= '0;
      b_gmax  <= '0;
      b_gidx  <= '0;
      b_sat   <= 1'b0;
      b_hit   <= 1'b0;
      b_hidx  <= '0;
      b_psum  <= '0;
    end else begin
      b_valid <= a_valid;
      if (a_valid) begin
        b_mode  <= a_mode;
        b_total <= m_total;
        b_gmax  <= m_gmax;
        b_gidx  <= m_gidx;
        b_sat   <= m_sat;
        b_hit   <= m_hit;
        b_hidx  <= m_hidx;
        b_psum  <= a_psum;
      end
    end
  end

  // stage C: pack and hold
  logic [LINK_W-1:0] c_word;

  chsum_pack #(.N_PATCH(N_PATCH), .CH_W(CH_W), .PS_W(PS_W), .IDX_W(IDX_W),
               .PIDX_W(PIDX_W), .SUM_W(SUM_W)) u_pack (
    .mode (b_mode), .total (b_total), .gmax (b_gmax), .gidx (b_gidx),
    .any_sat (b_sat), .psum_f (b_psum), .hit (b_hit), .hit_idx (b_hidx),
    .word (c_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      link_word <= '0;
    end else begin
      out_valid <= b_valid;
      if (b_valid) link_word <= c_word;
    end
  end

  // named internal events for the checker
  logic ev_a_fire, ev_a_any_sat, ev_b_sat;
  assign ev_a_fire    = a_valid;
  assign ev_a_any_sat = |a_lsat;
  assign ev_b_sat     = b_sat;
endmodule

// File: rtl/chsum_checker.sv
module chsum_checker #(
  parameter int CH_W   = 10,
  parameter int IDX_W  = 4,
  parameter int SUM_W  = 14,
  parameter int LINK_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [LINK_W-1:0] link_word,
  input logic              ev_a_fire,
  input logic              ev_a_any_sat,
  input logic              ev_b_sat
);
  localparam int MAX_LSB = LINK_W - 2 - IDX_W - CH_W;
  localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic full_mode;
  assign full_mode = out_valid && !link_word[LINK_W-1];

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> $stable(link_word));

  assert_full_scale_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_mode && link_word[MAX_LSB +: CH_W] == FULL) |-> link_word[LINK_W-2]);

  assert_sum_covers_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode |-> (link_word[SUM_W-1:0] >= SUM_W'(link_word[MAX_LSB +: CH_W])));

  assert_gap_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode |-> (link_word[MAX_LSB-1:SUM_W] == '0));

  assert_sat_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && ev_a_fire) |=> (ev_b_sat == $past(ev_a_any_sat)));
endmodule

bind chsum_maxfind_top chsum_checker #(
  .CH_W(CH_W), .IDX_W(IDX_W), .SUM_W(SUM_W), .LINK_W(chsum_pkg::LINK_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .out_valid (out_valid),
  .link_word (link_word), .ev_a_fire (ev_a_fire), .ev_a_any_sat (ev_a_any_sat),
  .ev_b_sat (ev_b_sat)
);

// File: tb/tb_chsum_maxfind_top.sv
`timescale 1ns/1ps
module tb_chsum_maxfind_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [159:0] in_charges = '0;
  logic         patch_mode = 1'b0;
  logic [11:0]  patch_thr = '0;
  logic         out_valid;
  logic [47:0]  link_word;

  always #4 clk = ~clk;

  chsum_maxfind_top dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_charges (in_charges),
    .patch_mode (patch_mode), .patch_thr (patch_thr),
    .out_valid (out_valid), .link_word (link_word)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [47:0] pe [3];
  bit          pv [3];
  logic [47:0] last_word = '0;

  function automatic logic [47:0] model(input logic [9:0] c [16], input bit m, input int thr);
    logic [47:0] w;
    int s, best, bi, ps;
    bit sat, found;
    w = '0;
    if (!m) begin
      s = 0; best = 0; bi = 15; sat = 0;
      for (int i = 15; i >= 0; i--) begin
        s += int'(c[i]);
        if (int'(c[i]) >= best) begin best = int'(c[i]); bi = i; end
        if (c[i] == 10'h3FF) sat = 1;
      end
      w[13:0]  = s[13:0];
      w[41:32] = best[9:0];
      w[45:42] = bi[3:0];
      w[46]    = sat;
    end else begin
      found = 0;
      for (int p = 0; p < 4; p++) begin
        ps = 0;
        for (int k = 0; k < 4; k++) ps += int'(c[4*p+k]);
        w[p*11 +: 11] = ps[11:1];
        if (!found && ps > thr) begin
          found = 1; w[46] = 1'b1; w[45:44] = p[1:0];
        end
      end
      w[47] = 1'b1;
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare output against the set applied three negedges ago, then apply the next
  task automatic step(input bit v, input logic [9:0] c [16], input bit m, input int thr);
    logic [47:0] e;
    e = pe[2];
    chk(out_valid == pv[2], "R7 out_valid", {47'd0, out_valid}, {47'd0, pv[2]});
    if (pv[2]) begin
      chk(link_word[47] == e[47], "R4 mode bit", link_word, e);
      if (!e[47]) begin
        chk(link_word[31:0]  == e[31:0],  "R1 sum field", link_word, e);
        chk(link_word[45:32] == e[45:32], "R2 max/index", link_word, e);
        chk(link_word[46]    == e[46],    "R3 saturation", link_word, e);
      end else begin
        chk(link_word[43:0]  == e[43:0],  "R5 patch sums", link_word, e);
        chk(link_word[46:44] == e[46:44], "R6 patch hit", link_word, e);
      end
      last_word = e;
    end else begin
      chk(link_word == last_word, "R8 hold", link_word, last_word);
    end
    pe[2] = pe[1]; pv[2] = pv[1];
    pe[1] = pe[0]; pv[1] = pv[0];
    pe[0] = model(c, m, thr); pv[0] = v;
    in_valid   = v;
    patch_mode = m;
    patch_thr  = thr[11:0];
    for (int i = 0; i < 16; i++) in_charges[i*10 +: 10] = c[i];
    @(negedge clk);
  endtask

  logic [9:0] ch [16];

  task automatic fill(input int v);
    for (int i = 0; i < 16; i++) ch[i] = v[9:0];
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) begin pe[i] = '0; pv[i] = 0; end
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0 && link_word == '0, "R8 reset", link_word, '0);
    rst_n = 1'b1;

    // R1/R2: all zero -> index 0
    fill(0); step(1, ch, 0, 0);
    // R1/R3: all full scale, sum 16368, sat set, index 0
    fill(1023); step(1, ch, 0, 0);
    // R2: tie at channels 5 and 9
    fill(100); ch[5] = 800; ch[9] = 800; step(1, ch, 0, 0);
    // R2: ramp, max at top channel
    for (int i = 0; i < 16; i++) ch[i] = 10'(i * 60);
    step(1, ch, 0, 0);
    // R3: one channel full scale, others small
    fill(3); ch[12] = 1023; step(1, ch, 0, 0);
    // R6: threshold equal to patch sum (no hit), then one below (hit at patch 2)
    fill(10); ch[8] = 500; ch[9] = 500;
    step(1, ch, 1, 1020);
    step(1, ch, 1, 1019);
    // R6: nothing over threshold
    fill(5); step(1, ch, 1, 4000);
    // R5/R6: full scale patches, threshold 0
    fill(1023); step(1, ch, 1, 0);
    // R8: gap in valid holds the word
    fill(77); step(0, ch, 0, 0); step(0, ch, 1, 0);
    // R9: mode and threshold flip every cycle, back to back
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 16; i++) ch[i] = 10'($urandom_range(0, 1023));
      step(1, ch, k[0], (k % 3) * 900);
    end

    // random phase
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 16; i++)
        ch[i] = ($urandom_range(0, 7) == 0) ? 10'h3FF : 10'($urandom_range(0, 1023));
      if ($urandom_range(0, 5) == 0) ch[$urandom_range(0, 15)] = ch[$urandom_range(0, 15)];
      step($urandom_range(0, 3) != 0, ch, $urandom_range(0, 1) == 1, int'($urandom_range(0, 4095)));
    end
    // drain
    fill(0);
    repeat (4) step(0, ch, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule